// File: doc/BRIEF.md
# Interprocessor Interrupt Destination Matcher

This block takes the decoded fields of an interprocessor interrupt command and decides which of `N_TGT` target agents receive it. Each target describes itself through its 8-bit physical ID, its 8-bit logical ID, its logical destination format nibble, a present bit and an enable bit. The requester also supplies the index of the sending target. Fixed-style deliveries go to every matched target. A lowest-priority delivery goes to exactly one target. That target is picked by a round-robin search over the matched targets that are also enabled.

A request enters through a valid/ready handshake. The matcher holds one result register. A request is accepted when `req_valid` and `req_ready` are both high. Its target vector then appears on `out_targets`, together with `out_valid`, on the next cycle. The result is held until `out_ready` is high. `req_ready` is low only while an unconsumed result waits on a stalled output, so back-pressure on the output stalls the input with no extra cycle of delay.

Top module: `ipi_dest_matcher`

## Requirements
- R1: `req_ready` equals `!out_valid || out_ready`. An accepted request raises `out_valid` on the next cycle. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_targets` hold their values.
- R2: With shorthand 00 (none) and physical mode (`icr_dest_logical` = 0, command bit 11), a present target matches when `icr_dest` (command-high bits [31:24]) equals its physical ID, or when `icr_dest` is 0xFF.
- R3: In logical mode, a present target whose format nibble is 0xF (flat) matches when its logical ID ANDed with `icr_dest` is nonzero.
- R4: In logical mode, a present target whose format nibble is 0x0 (cluster) matches when the upper nibbles of its logical ID and of `icr_dest` are equal and the lower nibbles share a set bit. Any other format nibble never matches in logical mode.
- R5: The shorthand field (command bits [19:18]) is decoded as follows: 01 matches only the source target, 10 matches every present target, and 11 matches every present target except the source. `icr_dest` is ignored for these values.
- R6: The delivery mode field (command bits [10:8]) selects the delivery. Any value other than 001 delivers to every matched target, whether or not that target is enabled.
- R7: Delivery mode 001 (lowest priority) delivers to one target: the first target that is both matched and enabled, searching upward from the index after the previous choice and wrapping at `N_TGT`. That index becomes the new previous choice.
- R8: When no matched target is enabled in lowest-priority mode, the result is an all-zero vector, still strobed by `out_valid`. The previous choice is left unchanged.
- R9: A target whose present bit is low never appears in `out_targets`.
- R10: Reset clears `out_valid` and sets the previous choice to `N_TGT-1`, so the first lowest-priority search begins at target 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with `req_valid` |
| icr_shorthand | input | 2 | Destination shorthand, command bits [19:18] |
| icr_dest_logical | input | 1 | Destination mode, command bit 11 (1 = logical) |
| icr_deliv_mode | input | 3 | Delivery mode, command bits [10:8] (001 = lowest priority) |
| icr_dest | input | 8 | Destination byte, command-high bits [31:24] |
| src_idx | input | SRC_W | Index of the sending target |
| tgt_phys_id | input | N_TGT*8 | Physical ID per target, target i in bits [8i+7:8i] |
| tgt_log_id | input | N_TGT*8 | Logical ID per target |
| tgt_fmt | input | N_TGT*4 | Logical format nibble per target (0xF flat, 0x0 cluster) |
| tgt_present | input | N_TGT | Target exists |
| tgt_en | input | N_TGT | Target enabled for lowest-priority selection |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumer ready |
| out_targets | output | N_TGT | Delivery vector, bit i selects target i |

## Verification
The only hidden state is the round-robin pointer. A wrong value shows up on the very next lowest-priority result as a grant to the wrong target, or to a skipped or repeated one. The bench runs a full rotation through gaps made by absent and disabled targets. It then checks that a miss leaves the rotation untouched and that a reset restarts it at target 0. A fault in the output register shows within one cycle of a stall, as a changed vector or a dropped `out_valid` while `out_ready` is low.

// File: rtl/ipi_match_pkg.sv
package ipi_match_pkg;
  localparam int ID_W  = 8;
  localparam int NIB_W = ID_W / 2;
  localparam int FMT_W = 4;

  typedef enum logic [1:0] {
    SH_NONE   = 2'b00,
    SH_SELF   = 2'b01,
    SH_ALL    = 2'b10,
    SH_OTHERS = 2'b11
  } shorthand_e;

  localparam logic [2:0]       DELIV_LOWEST = 3'b001;
  localparam logic [FMT_W-1:0] FMT_FLAT     = 4'hF;
  localparam logic [FMT_W-1:0] FMT_CLUSTER  = 4'h0;
  localparam logic [ID_W-1:0]  PHYS_BCAST   = 8'hFF;
endpackage

// File: rtl/ipi_addr_match.sv
module ipi_addr_match
  import ipi_match_pkg::*;
(
  input  logic [1:0]       shorthand,
  input  logic             dest_logical,
  input  logic [ID_W-1:0]  dest,
  input  logic             is_src,
  input  logic             present,
  input  logic [ID_W-1:0]  phys_id,
  input  logic [ID_W-1:0]  log_id,
  input  logic [FMT_W-1:0] fmt,
  output logic             hit
);
  logic addr_hit;
  logic flat_hit;
  logic clus_hit;

  always_comb begin
    flat_hit = |(log_id & dest);
    clus_hit = (log_id[ID_W-1:NIB_W] == dest[ID_W-1:NIB_W]) &&
               (|(log_id[NIB_W-1:0] & dest[NIB_W-1:0]));
    if (!dest_logical)
      addr_hit = (dest == PHYS_BCAST) || (dest == phys_id);
    else if (fmt == FMT_FLAT)
      addr_hit = flat_hit;
    else if (fmt == FMT_CLUSTER)
      addr_hit = clus_hit;
    else
      addr_hit = 1'b0;
  end

  always_comb begin
    unique case (shorthand_e'(shorthand))
      SH_NONE:   hit = present && addr_hit;
      SH_SELF:   hit = present && is_src;
      SH_ALL:    hit = present;
      SH_OTHERS: hit = present && !is_src;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/ipi_rr_pick.sv
module ipi_rr_pick #(
  parameter int N_TGT = 8,
  localparam int SRC_W = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_TGT-1:0] cand,
  input  logic             advance,
  output logic [N_TGT-1:0] grant
);
  logic [SRC_W-1:0] prev_q;
  logic [SRC_W-1:0] pick_idx;
  logic             found;

  always_comb begin
    int j;
    grant    = '0;
    pick_idx = prev_q;
    found    = 1'b0;
    for (int k = 0; k < N_TGT; k++) begin
      j = int'(prev_q) + 1 + k;
      if (j >= N_TGT) j = j - N_TGT;
      if (!found && cand[j]) begin
        found       = 1'b1;
        grant[j]    = 1'b1;
        pick_idx    = SRC_W'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      prev_q <= SRC_W'(N_TGT - 1);
    else if (advance && found)
      prev_q <= pick_idx;
  end
endmodule

// File: rtl/ipi_dest_matcher.sv
module ipi_dest_matcher
  import ipi_match_pkg::*;
#(
  parameter int N_TGT = 8,
  localparam int SRC_W = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [1:0]              icr_shorthand,
  input  logic                    icr_dest_logical,
  input  logic [2:0]              icr_deliv_mode,
  input  logic [ID_W-1:0]         icr_dest,
  input  logic [SRC_W-1:0]        src_idx,
  input  logic [N_TGT*ID_W-1:0]   tgt_phys_id,
  input  logic [N_TGT*ID_W-1:0]   tgt_log_id,
  input  logic [N_TGT*FMT_W-1:0]  tgt_fmt,
  input  logic [N_TGT-1:0]        tgt_present,
  input  logic [N_TGT-1:0]        tgt_en,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [N_TGT-1:0]        out_targets
);
  logic [N_TGT-1:0] match_vec;
  logic [N_TGT-1:0] lp_grant;
  logic [N_TGT-1:0] next_targets;
  logic             accept;
  logic             lowest;

  assign req_ready = !out_valid || out_ready;
  assign accept    = req_valid && req_ready;
  assign lowest    = (icr_deliv_mode == DELIV_LOWEST);

  for (genvar i = 0; i < N_TGT; i++) begin : g_tgt
    ipi_addr_match u_match (
      .shorthand    (icr_shorthand),
      .dest_logical (icr_dest_logical),
      .dest         (icr_dest),
      .is_src       (src_idx == SRC_W'(i)),
      .present      (tgt_present[i]),
      .phys_id      (tgt_phys_id[i*ID_W +: ID_W]),
      .log_id       (tgt_log_id[i*ID_W +: ID_W]),
      .fmt          (tgt_fmt[i*FMT_W +: FMT_W]),
      .hit          (match_vec[i])
    );
  end

  ipi_rr_pick #(.N_TGT(N_TGT)) u_rr (
    .clk     (clk),
    .rst_n   (rst_n),
    .cand    (match_vec & tgt_en),
    .advance (accept && lowest),
    .grant   (lp_grant)
  );

  assign next_targets = lowest ? lp_grant : match_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_targets <= '0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_targets <= next_targets;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/ipi_dest_matcher_chk.sv
module ipi_dest_matcher_chk #(
  parameter int N_TGT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [1:0]       icr_shorthand,
  input logic [2:0]       icr_deliv_mode,
  input logic [N_TGT-1:0] tgt_present,
  input logic [N_TGT-1:0] tgt_en,
  input logic             out_valid,
  input logic             out_ready,
  input logic [N_TGT-1:0] out_targets
);
  logic acc;
  assign acc = req_valid && req_ready;

  assert_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> req_ready);

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_targets)));

  assert_self_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && icr_shorthand == 2'b01) |=> ($countones(out_targets) <= 1));

  assert_lowest_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && icr_deliv_mode == 3'b001) |=> $onehot0(out_targets));

  assert_lowest_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && icr_deliv_mode == 3'b001) |=> ((out_targets & ~$past(tgt_en)) == '0));

  assert_present_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> ((out_targets & ~$past(tgt_present)) == '0));
endmodule

bind ipi_dest_matcher ipi_dest_matcher_chk #(.N_TGT(N_TGT)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .icr_shorthand  (icr_shorthand),
  .icr_deliv_mode (icr_deliv_mode),
  .tgt_present    (tgt_present),
  .tgt_en         (tgt_en),
  .out_valid      (out_valid),
  .out_ready      (out_ready),
  .out_targets    (out_targets)
);

// File: tb/ipi_dest_matcher_tb.sv
module ipi_dest_matcher_tb;
  localparam int N = 8;
  localparam int NROW = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [1:0]   icr_shorthand = '0;
  logic         icr_dest_logical = 1'b0;
  logic [2:0]   icr_deliv_mode = '0;
  logic [7:0]   icr_dest = '0;
  logic [2:0]   src_idx = '0;
  logic [N*8-1:0] tgt_phys_id;
  logic [N*8-1:0] tgt_log_id;
  logic [N*4-1:0] tgt_fmt;
  logic [N-1:0] tgt_present;
  logic [N-1:0] tgt_en;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [N-1:0] out_targets;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ipi_dest_matcher #(.N_TGT(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .icr_shorthand(icr_shorthand), .icr_dest_logical(icr_dest_logical),
    .icr_deliv_mode(icr_deliv_mode), .icr_dest(icr_dest), .src_idx(src_idx),
    .tgt_phys_id(tgt_phys_id), .tgt_log_id(tgt_log_id), .tgt_fmt(tgt_fmt),
    .tgt_present(tgt_present), .tgt_en(tgt_en), .out_valid(out_valid),
    .out_ready(out_ready), .out_targets(out_targets)
  );

  // Row: {shorthand, logical, deliv, dest, src, expected}
  // Targets: phys id 0x10+i; 0..3 flat with logical 1<<i; 4..7 cluster
  // with logical 0x20|(1<<(i-4)); target 6 absent; target 4 disabled.
  localparam logic [1:0] T_SH  [NROW] = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 2'd1, 2'd2, 2'd3};
  localparam logic       T_LOG [NROW] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam logic [7:0] T_DST [NROW] = '{8'h12, 8'hFF, 8'h16, 8'h05, 8'h23, 8'h30, 8'h55, 8'h00, 8'h11, 8'h00};
  localparam logic [2:0] T_SRC [NROW] = '{3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd3, 3'd6, 3'd2, 3'd0};
  localparam logic [7:0] T_EXP [NROW] = '{8'h04, 8'hBF, 8'h00, 8'h05, 8'h33, 8'h00, 8'h08, 8'h00, 8'hBF, 8'hBE};

  function automatic string row_req(int r);
    case (r)
      0:       return "R2 physical id";
      1:       return "R6 R2 broadcast ignores enable";
      2:       return "R9 absent target";
      3:       return "R3 flat logical";
      4:       return "R4 cluster and flat mix";
      5:       return "R4 cluster nibble mismatch";
      6:       return "R5 self ignores dest";
      7:       return "R9 self absent";
      8:       return "R5 all including";
      default: return "R5 all excluding";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] sh, input logic lg, input logic [2:0] dm,
                      input logic [7:0] d, input logic [2:0] s, output logic [7:0] res);
    @(negedge clk);
    icr_shorthand = sh; icr_dest_logical = lg; icr_deliv_mode = dm;
    icr_dest = d; src_idx = s; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 valid after accept", {7'd0, out_valid}, 8'd1);
    res = out_targets;
  endtask

  task automatic pulse_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    logic [7:0] r;
    for (int i = 0; i < N; i++) begin
      tgt_phys_id[i*8 +: 8] = 8'h10 + 8'(i);
      tgt_log_id[i*8 +: 8]  = (i < 4) ? 8'(1 << i) : (8'h20 | 8'(1 << (i - 4)));
      tgt_fmt[i*4 +: 4]     = (i < 4) ? 4'hF : 4'h0;
    end
    tgt_present = 8'hBF;
    tgt_en      = 8'hEF;
    repeat (3) @(negedge clk);
    check("R10 reset out_valid", {7'd0, out_valid}, 8'd0);
    check("R1 ready after reset", {7'd0, req_ready}, 8'd1);
    rst_n = 1'b1;

    for (int k = 0; k < NROW; k++) begin
      send(T_SH[k], T_LOG[k], 3'b000, T_DST[k], T_SRC[k], r);
      check(row_req(k), r, T_EXP[k]);
    end

    // R4: unknown format nibble never matches
    tgt_fmt[3:0] = 4'h5;
    send(2'd0, 1'b1, 3'b000, 8'h01, 3'd0, r);
    check("R4 bad format", r, 8'h00);
    tgt_fmt[3:0] = 4'hF;

    // R7 rotation with R10 start at target 0
    pulse_reset();
    send(2'd0, 1'b0, 3'b001, 8'hFF, 3'd0, r); check("R10 R7 first pick", r, 8'h01);
    send(2'd0, 1'b0, 3'b001, 8'hFF, 3'd0, r); check("R7 pick 1", r, 8'h02);
    send(2'd0, 1'b0, 3'b001, 8'hFF, 3'd0, r); check("R7 pick 2", r, 8'h04);
    send(2'd0, 1'b0, 3'b001, 8'hFF, 3'd0, r); check("R7 pick 3", r, 8'h08);
    send(2'd0, 1'b0, 3'b001, 8'hFF, 3'd0, r); check("R7 skip disabled", r, 8'h20);
    send(2'd0, 1'b0, 3'b001, 8'hFF, 3'd0, r); check("R7 R9 skip absent", r, 8'h80);
    send(2'd0, 1'b0, 3'b001, 8'hFF, 3'd0, r); check("R7 wrap", r, 8'h01);
    // R8: only disabled target matched
    send(2'd0, 1'b0, 3'b001, 8'h14, 3'd0, r); check("R8 empty", r, 8'h00);
    send(2'd0, 1'b0, 3'b001, 8'hFF, 3'd0, r); check("R8 pointer kept", r, 8'h02);
    send(2'd3, 1'b0, 3'b001, 8'h00, 3'd3, r); check("R7 R5 others lowest", r, 8'h04);
    pulse_reset();
    send(2'd0, 1'b0, 3'b001, 8'hFF, 3'd0, r); check("R10 pointer reset", r, 8'h01);

    // R1 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    icr_shorthand = 2'd0; icr_dest_logical = 1'b0; icr_deliv_mode = 3'b000;
    icr_dest = 8'h13; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    icr_dest = 8'h11;
    check("R1 stalled valid", {7'd0, out_valid}, 8'd1);
    check("R1 stalled ready low", {7'd0, req_ready}, 8'd0);
    repeat (2) @(negedge clk);
    check("R1 stalled hold", out_targets, 8'h08);
    check("R1 stalled still valid", {7'd0, out_valid}, 8'd1);
    out_ready = 1'b1;
    @(negedge clk);
    check("R1 drained", {7'd0, out_valid}, 8'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule